// File: doc/BRIEF.md
# Three-Level Decision Feedback Equalizer

This block sits on the receive side of a link that carries three-level symbols. Each clock cycle with `in_vld` high delivers one signed fixed-point sample. The block adds up the interference that earlier decisions leave on that sample, one tap weight per earlier symbol position, and subtracts it. The result is clamped to the sample range and compared against a symmetric pair of thresholds. Each sample is resolved to -1, 0 or +1.

The tap weights adapt on line with a least-mean-square rule driven by the decided symbols. The error term is the equalized sample minus the ideal level of the symbol that was decided. For each tap, that error is multiplied by the ternary symbol in the matching history slot. The product is scaled down by a programmable power of two with rounding and added to the weight. Software-style controls set the threshold, the ideal level, the step size and the adaptation enable. A selector reads back any single tap. A synchronous clear returns the weights and the history to zero.

Top module: `pam3_dfe`

## Requirements
- R1: Each decided symbol is presented on `out_sym` as a 2-bit code: 2'b00 for 0, 2'b01 for +1, 2'b11 for -1. The code 2'b10 never appears while `out_vld` is high.
- R2: The equalized sample decides +1 when it is strictly greater than `thr` and -1 when it is strictly less than -`thr`. Otherwise it decides 0. A value exactly equal to ±`thr` decides 0.
- R3: The feedback for sample n is the sum over taps j of w[j]·d[n-1-j]. Here d are the earlier decisions (+1, -1 or 0), and tap 0 belongs to the most recent decision. The feedback uses only decisions up to n-1.
- R4: The equalized sample is `in_smp` minus the feedback, saturated to the signed SW-bit range rather than wrapped.
- R5: When adaptation is on, every valid sample updates each tap. The update is w[j] += round((e·d[n-1-j]) / 2^`mu_sh`), where e = equalized − (`lvl`·decided symbol). The division is computed as (x + 2^(`mu_sh`-1)) >>> `mu_sh` for `mu_sh` > 0 and is exact for 0. A zero in a history slot leaves that tap unchanged.
- R6: `out_vld` rises exactly one clock after a cycle with `in_vld` high and stays low after a cycle with `in_vld` low.
- R7: With `adapt_en` low, all tap weights hold their values.
- R8: Reset (`rst_n` low) or a cycle with `clr` high sets all taps and the whole history to zero and drops `out_vld`.
- R9: Tap weights are signed WW-bit registers that saturate at their most positive and most negative values instead of wrapping.
- R10: `tap_val` shows the weight of tap `tap_sel` while `tap_sel` < NTAP, and reads zero for any higher selector value.
- R11: Cycles with `in_vld` low change neither the history nor the weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of taps and history |
| in_vld | input | 1 | Sample valid |
| in_smp | input | SW | Signed received sample |
| thr | input | SW-1 | Decision threshold magnitude |
| lvl | input | SW-1 | Ideal magnitude of a ±1 symbol |
| mu_sh | input | MW | Adaptation step as a right shift |
| adapt_en | input | 1 | Enables tap adaptation |
| tap_sel | input | $clog2(NTAP) | Tap readback selector |
| tap_val | output | WW | Selected tap weight |
| out_vld | output | 1 | Decision valid |
| out_sym | output | 2 | Decided symbol code |

## Verification
The bench sweeps every possible input value with zero taps. This finds slicer mistakes: a design using `>=` instead of `>` would decide ±1 at exactly ±`thr`, and one with a sign slip would swap the two outer symbols.

A channel with known post-cursors runs with adaptation on. A design that used the current decision in its feedback, or misordered the history, would converge to the wrong taps or miss symbols.

A full-scale random stress with a zero step and idle gaps is compared against an arithmetic model. It drives the weights and the equalized sample into their limits. A design that wrapped instead of clamping, or that shifted history on idle cycles, would diverge from the model within a few samples.

Freeze, clear and out-of-range readback are each checked at the ports.

// File: rtl/pam3_dfe.sv
module pam3_dfe #(
  parameter int SW   = 10,
  parameter int WW   = 10,
  parameter int NTAP = 5,
  parameter int MW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_vld,
  input  logic signed [SW-1:0]      in_smp,
  input  logic [SW-2:0]             thr,
  input  logic [SW-2:0]             lvl,
  input  logic [MW-1:0]             mu_sh,
  input  logic                      adapt_en,
  input  logic [$clog2(NTAP)-1:0]   tap_sel,
  output logic signed [WW-1:0]      tap_val,
  output logic                      out_vld,
  output logic [1:0]                out_sym
);
  localparam int AW = WW + $clog2(NTAP) + 2;
  localparam int DW = ((AW > SW) ? AW : SW) + 1;
  localparam logic signed [DW-1:0] SMAX = DW'((2 ** (SW - 1)) - 1);
  localparam logic signed [DW-1:0] SMIN = -SMAX - 1;
  localparam int WMAX = (2 ** (WW - 1)) - 1;
  localparam int WMIN = -WMAX - 1;

  logic signed [WW-1:0] w  [NTAP];
  logic signed [WW-1:0] wn [NTAP];
  logic [1:0]           hist [NTAP];
  logic signed [AW-1:0] fb;
  logic signed [DW-1:0] diff, eqx, thx, lvx, ideal, err;
  logic                 pos, neg;
  logic [1:0]           sym;

  always_comb begin
    fb = '0;
    for (int j = 0; j < NTAP; j++)
      case (hist[j])
        2'b01:   fb = fb + AW'(w[j]);
        2'b11:   fb = fb - AW'(w[j]);
        default: ;
      endcase
  end

  assign diff = DW'(in_smp) - DW'(fb);
  assign eqx  = (diff > SMAX) ? SMAX : (diff < SMIN) ? SMIN : diff;
  assign thx  = DW'($signed({1'b0, thr}));
  assign lvx  = DW'($signed({1'b0, lvl}));
  assign pos  = eqx > thx;
  assign neg  = eqx < -thx;
  assign sym  = pos ? 2'b01 : (neg ? 2'b11 : 2'b00);
  assign ideal = pos ? lvx : (neg ? -lvx : '0);
  assign err  = eqx - ideal;

  function automatic logic signed [WW-1:0] step_tap(
    input logic signed [WW-1:0] wv, input logic [1:0] hv,
    input logic signed [DW-1:0] ev, input logic [MW-1:0] sh);
    logic signed [31:0] x, rnd, nv;
    x   = (hv == 2'b01) ? 32'(ev) : (hv == 2'b11) ? -32'(ev) : 32'sd0;
    rnd = (sh == '0) ? 32'sd0 : (32'sd1 <<< (sh - 1'b1));
    nv  = 32'(wv) + ((x + rnd) >>> sh);
    if (nv > WMAX) nv = WMAX;
    if (nv < WMIN) nv = WMIN;
    return nv[WW-1:0];
  endfunction

  always_comb
    for (int j = 0; j < NTAP; j++) wn[j] = step_tap(w[j], hist[j], err, mu_sh);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      out_vld <= 1'b0;
      out_sym <= 2'b00;
      for (int j = 0; j < NTAP; j++) begin
        w[j]    <= '0;
        hist[j] <= 2'b00;
      end
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_sym <= sym;
        hist[0] <= sym;
        for (int j = 1; j < NTAP; j++) hist[j] <= hist[j-1];
        if (adapt_en)
          for (int j = 0; j < NTAP; j++) w[j] <= wn[j];
      end
    end
  end

  assign tap_val = (32'(tap_sel) < NTAP) ? w[tap_sel] : '0;
endmodule

// File: rtl/pam3_dfe_chk.sv
module pam3_dfe_chk #(
  parameter int WW  = 10,
  parameter int TSW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   in_vld,
  input logic                   adapt_en,
  input logic [TSW-1:0]         tap_sel,
  input logic signed [WW-1:0]   tap_val,
  input logic                   out_vld,
  input logic [1:0]             out_sym
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_sym != 2'b10));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !clr) |=> out_vld);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  a_r7_frozen_taps: assert property (@(posedge clk) disable iff (!rst_n)
    (!adapt_en && !clr) |=> (!$stable(tap_sel) || $stable(tap_val)));

  a_r8_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap_val == '0 && !out_vld));
endmodule

bind pam3_dfe pam3_dfe_chk #(.WW(WW), .TSW($clog2(NTAP))) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .adapt_en(adapt_en),
  .tap_sel(tap_sel), .tap_val(tap_val), .out_vld(out_vld), .out_sym(out_sym));

// File: tb/sim_pam3_dfe.sv
`timescale 1ns/100ps
module sim_pam3_dfe;
  localparam int SW = 10, WW = 10, NT = 5, MW = 4;
  localparam int SMX = 511, SMN = -512, WMX = 511, WMN = -512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, clr, in_vld, adapt_en, out_vld;
  logic signed [SW-1:0] in_smp;
  logic [SW-2:0] thr, lvl;
  logic [MW-1:0] mu_sh;
  logic [2:0] tap_sel;
  logic signed [WW-1:0] tap_val;
  logic [1:0] out_sym;

  pam3_dfe #(.SW(SW), .WW(WW), .NTAP(NT), .MW(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_smp(in_smp),
    .thr(thr), .lvl(lvl), .mu_sh(mu_sh), .adapt_en(adapt_en), .tap_sel(tap_sel),
    .tap_val(tap_val), .out_vld(out_vld), .out_sym(out_sym));

  int checks = 0, errors = 0;
  int mw[NT], md[NT], keep[NT];
  bit sat_seen = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int dec(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return -1;
      default: return 9;
    endcase
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic mclear();
    for (int j = 0; j < NT; j++) begin mw[j] = 0; md[j] = 0; end
  endtask

  function automatic int model(input int smp);
    int fb, eq, s, e, x, d;
    fb = 0;
    for (int j = 0; j < NT; j++) fb += mw[j] * md[j];
    eq = clampi(smp - fb, SMN, SMX);
    s  = (eq > int'(thr)) ? 1 : (eq < -int'(thr)) ? -1 : 0;
    e  = eq - int'(lvl) * s;
    if (adapt_en)
      for (int j = 0; j < NT; j++) begin
        x = e * md[j];
        d = (mu_sh == 0) ? x : ((x + (1 << (int'(mu_sh) - 1))) >>> int'(mu_sh));
        mw[j] = clampi(mw[j] + d, WMN, WMX);
      end
    for (int j = NT - 1; j > 0; j--) md[j] = md[j-1];
    md[0] = s;
    return s;
  endfunction

  task automatic cmp_taps(input string rq);
    for (int j = 0; j < NT; j++) begin
      tap_sel = 3'(j);
      #0.2;
      chk(int'(tap_val) == mw[j], rq, int'(tap_val), mw[j]);
      if (int'(tap_val) == mw[j] && (mw[j] == WMX || mw[j] == WMN)) sat_seen = 1;
    end
  endtask

  int last_sym;
  task automatic step(input bit v, input int smp, input string rq);
    int e;
    @(negedge clk);
    in_vld = v;
    in_smp = smp[SW-1:0];
    @(posedge clk);
    #1;
    chk(out_vld == v, "R6", int'(out_vld), int'(v));
    if (v) begin
      e = model(smp);
      last_sym = dec(out_sym);
      chk(out_sym != 2'b10, "R1", int'(out_sym), 0);
      chk(last_sym == e, rq, last_sym, e);
    end
    cmp_taps(rq);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1; in_vld = 1; in_smp = 10'sd300;
    @(posedge clk);
    #1;
    mclear();
    chk(out_vld == 0, "R8", int'(out_vld), 0);
    cmp_taps("R8");
    @(negedge clk);
    clr = 0; in_vld = 0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, rx, exp;
    int tx[4];
    int hc[NT];
    hc = '{24, -12, 6, -3, 0};
    rst_n = 0; clr = 0; in_vld = 0; in_smp = '0; adapt_en = 0;
    thr = 9'd40; lvl = 9'd100; mu_sh = 4'd2; tap_sel = '0;
    mclear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_vld == 0, "R8", int'(out_vld), 0);
    cmp_taps("R8");

    // R2: every sample value with zero taps, adaptation off
    for (int v = SMN; v <= SMX; v++) begin
      step(1, v, "R2");
      exp = (v > 40) ? 1 : (v < -40) ? -1 : 0;
      chk(last_sym == exp, "R2", last_sym, exp);
    end

    // R3/R5: converge on a known post-cursor channel
    do_clear();
    thr = 9'd50; lvl = 9'd100; mu_sh = 4'd2; adapt_en = 1;
    for (int k = 0; k < 4; k++) tx[k] = 0;
    for (int n = 0; n < 3000; n++) begin
      s  = int'($urandom % 3) - 1;
      rx = 100 * s + hc[0] * tx[0] + hc[1] * tx[1] + hc[2] * tx[2] + hc[3] * tx[3];
      step(1, rx, "R5");
      if (n >= 200) chk(last_sym == s, "R3", last_sym, s);
      for (int k = 3; k > 0; k--) tx[k] = tx[k-1];
      tx[0] = s;
    end
    for (int j = 0; j < NT; j++) begin
      tap_sel = 3'(j);
      #0.2;
      chk(int'(tap_val) >= hc[j] - 3 && int'(tap_val) <= hc[j] + 3, "R3", int'(tap_val), hc[j]);
    end

    // R7: freeze
    adapt_en = 0;
    for (int j = 0; j < NT; j++) keep[j] = mw[j];
    for (int n = 0; n < 300; n++) begin
      s  = int'($urandom % 3) - 1;
      rx = 100 * s + hc[0] * tx[0] + hc[1] * tx[1] + hc[2] * tx[2] + hc[3] * tx[3];
      step(1, rx, "R7");
      chk(last_sym == s, "R3", last_sym, s);
      for (int k = 3; k > 0; k--) tx[k] = tx[k-1];
      tx[0] = s;
    end
    for (int j = 0; j < NT; j++) chk(mw[j] == keep[j], "R7", mw[j], keep[j]);

    // R4/R9/R11: full-scale stress with gaps, exact step
    adapt_en = 1; mu_sh = 4'd0; thr = 9'd100; lvl = 9'd200;
    for (int n = 0; n < 1500; n++)
      step(($urandom % 4) != 0, int'($urandom % 1024) - 512, "R4 R9");
    chk(sat_seen, "R9", int'(sat_seen), 1);

    // R11: idle cycles leave state alone
    mu_sh = 4'd1;
    for (int j = 0; j < NT; j++) keep[j] = mw[j];
    for (int n = 0; n < 4; n++) step(0, 400, "R11");
    for (int j = 0; j < NT; j++) chk(mw[j] == keep[j], "R11", mw[j], keep[j]);
    step(1, 123, "R11");

    // R10: out-of-range selector
    for (int k = NT; k < 8; k++) begin
      tap_sel = 3'(k);
      #0.2;
      chk(tap_val == '0, "R10", int'(tap_val), 0);
    end

    do_clear();
    adapt_en = 0;
    step(1, 0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule